// File: doc/BRIEF.md
# PHY Management Frame Engine

This block drives the two-wire station management bus of an Ethernet PHY. Software stores one packed 32-bit maintenance word through a small register port. That word holds the start code, the opcode, the PHY and register addresses, the turnaround pattern and the 16 data bits. The engine then sends a preamble of ones followed by the whole word on the management data line, most significant bit first, timed by a management clock that it derives from the system clock.

For a read opcode, the engine stops driving the line from the second turnaround slot to the end of the frame. It samples the 16 bits that the PHY returns, and when the frame ends it writes them into the low half of the stored word. Software reads them back from there. A status register shows an idle flag, so software can poll for completion before it starts the next transaction.

Top module: `mgmt_frame_ctrl`

## Requirements
- R1: After the preamble, the 32 bits of the stored word go out most significant bit first. The word holds start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0].
- R2: Each frame opens with 32 preamble bits, all ones, which makes a frame 64 management clock periods long.
- R3: The management clock runs at the system clock divided by DIV (default 48), so its rising edges are exactly 48 system cycles apart during a frame. The data line changes only after a falling edge of the management clock.
- R4: With opcode 10 (read), output enable is low for frame slots 47 to 63: the second turnaround bit and the 16 data bits. With any other opcode, output enable stays high for all 64 slots.
- R5: On a read, the engine samples the line on each rising edge of the management clock during slots 48 to 63. When the frame ends, select 0 reads back the word with [15:0] replaced by the sampled bits, first bit in bit 15. Bits [31:16] are unchanged.
- R6: After a frame with a non-read opcode, select 0 reads back the written word unchanged.
- R7: Select 1 reads the status register. Bit 2 is 1 when idle and 0 while a frame is in progress, and all other bits read 0. Read data appears one cycle after the select.
- R8: A write to select 0 while mgmt_en is low is ignored. No frame starts and the stored word keeps its value.
- R9: A write to select 0 while a frame is in progress is ignored. The frame on the line and the stored word keep their values.
- R10: After reset and between frames, the management clock is low, output enable is low and the stored word reads 0 until it is first written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable; gates the start of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 maintenance word, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_sel |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A PHY model in the bench changes its reply bit just after each rising edge of the management clock. A design that sampled on the falling edge would therefore return the reply shifted by one bit. The bench records output enable in every one of the 64 slots, so a release that starts one slot early or late, or a release on a write, shows up as a wrong enable vector. Two directed cases check that writes are ignored: a second word written in the middle of a frame, and a word written while mgmt_en is low. A design that accepted either one would change the bits on the line or the stored word. All-ones and all-zeros replies check that the capture does not touch the upper half of the word, and opcode 11 checks that only opcode 10 releases the line.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS  = 32;
  localparam int WORD_BITS = 32;
  localparam int DATA_BITS = 16;
  localparam int MDC_DIV   = 48;

  localparam logic [1:0] OPC_READ = 2'b10;

  localparam logic [1:0] SEL_MAINT = 2'd0;
  localparam logic [1:0] SEL_STAT  = 2'd1;
  localparam int IDLE_BIT = 2;
endpackage

// File: rtl/mdc_clkdiv.sv
module mdc_clkdiv #(
  parameter int DIV = mgmt_pkg::MDC_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign rise_tk = run && (cnt == CW'(HALF - 1));
  assign fall_tk = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_tk) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_tk) mdc <= 1'b1;
    end
  end

  // R10: clock parks low once the engine stops
  p_mdc_low_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/frame_serdes.sv
module frame_serdes #(
  parameter int PRE_LEN = mgmt_pkg::PRE_BITS,
  parameter int WORD_W  = mgmt_pkg::WORD_BITS,
  parameter int DATA_W  = mgmt_pkg::DATA_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int TOTAL = PRE_LEN + WORD_W;
  localparam int LAST  = TOTAL - 1;
  localparam int REL   = TOTAL - DATA_W - 1;
  localparam int OPH   = WORD_W - 3;
  localparam int BW    = $clog2(TOTAL);

  logic [TOTAL-1:0] shreg;
  logic [TOTAL-1:0] new_frame;
  logic [BW-1:0]    bitcnt;
  logic [BW-1:0]    nxt;
  logic             is_rd;

  assign new_frame = {{PRE_LEN{1'b1}}, start_word};
  assign nxt       = bitcnt + 1'b1;
  assign done      = busy && fall_tk && (bitcnt == BW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      bitcnt  <= '0;
      shreg   <= new_frame;
      is_rd   <= (start_word[OPH -: 2] == mgmt_pkg::OPC_READ);
      mdio_o  <= new_frame[LAST];
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tk && is_rd && (bitcnt > BW'(REL)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall_tk) begin
        if (bitcnt == BW'(LAST)) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt  <= nxt;
          mdio_o  <= shreg[LAST - int'(nxt)];
          mdio_oe <= !(is_rd && (nxt >= BW'(REL)));
        end
      end
    end
  end

  // R4: line is released whenever no frame runs
  p_oe_low_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R4: a non-read frame drives every slot
  p_wr_driven_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_rd) |-> mdio_oe);
  // R3: data moves only on a falling management clock
  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_tk) |=> $stable(mdio_o));
endmodule

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl #(
  parameter int DIV     = mgmt_pkg::MDC_DIV,
  parameter int PRE_LEN = mgmt_pkg::PRE_BITS,
  parameter int WORD_W  = mgmt_pkg::WORD_BITS,
  parameter int DATA_W  = mgmt_pkg::DATA_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mgmt_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  import mgmt_pkg::*;
  localparam int OPH = WORD_W - 3;

  logic              busy, done, accept, rise_tk, fall_tk;
  logic [DATA_W-1:0] rd_data;
  logic [WORD_W-1:0] word_q;

  assign accept = reg_wr && (reg_sel == SEL_MAINT) && mgmt_en && !busy;

  mdc_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  frame_serdes #(.PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .start(accept), .start_word(reg_wdata),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= reg_wdata;
    end else if (done && (word_q[OPH -: 2] == OPC_READ)) begin
      word_q[DATA_W-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_MAINT: reg_rdata <= word_q;
        SEL_STAT:  reg_rdata <= WORD_W'(!busy) << IDLE_BIT;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R9: the stored word holds through a frame until its final slot
  p_word_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(word_q));
  // R8: no frame starts while the port is disabled
  p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!mgmt_en && !busy) |=> !busy);
endmodule

// File: tb/tb_mgmt_frame_ctrl.sv
`timescale 1ns/1ps
module tb_mgmt_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int nrise = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(posedge mdc) nrise++;

  mgmt_frame_ctrl dut (
    .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic bit is_read(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic [15:0] rep);
    return is_read(w) ? {w[31:16], rep} : w;
  endfunction

  function automatic logic [63:0] exp_oe(input logic [31:0] w);
    return is_read(w) ? {{47{1'b1}}, 17'b0} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] mk_word(input logic [1:0] op, input logic [4:0] pa,
                                          input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic run_frame(input logic [31:0] w, input logic [15:0] rep,
                           input bit inject, input logic [31:0] iw, input string tag);
    logic [63:0] seen, oes;
    logic [31:0] v, mask;
    int   tprev;
    bit   per_ok;
    per_ok = 1'b1; tprev = 0; seen = '0; oes = '0;
    wr(w);
    rd(2'd1, v);
    chk(v == 32'h0, {"R7 busy status ", tag}, 64'(v), 64'h0);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      seen[63-k] = mdio_o;
      oes[63-k]  = mdio_oe;
      if (k > 0 && (cyc - tprev) != 48) per_ok = 1'b0;
      tprev = cyc;
      #1;
      if (k + 1 >= 48 && k + 1 <= 63) mdio_i = rep[63-(k+1)];
      if (inject && k == 2) wr(iw);
    end
    repeat (40) @(posedge clk);
    chk(seen[63:32] == 32'hFFFF_FFFF, {"R2 preamble ", tag}, 64'(seen[63:32]), 64'hFFFF_FFFF);
    mask = is_read(w) ? 32'hFFFE_0000 : 32'hFFFF_FFFF;
    chk((seen[31:0] & mask) == (w & mask), {"R1 frame bits ", tag},
        64'(seen[31:0] & mask), 64'(w & mask));
    chk(oes == exp_oe(w), {"R4 output enable ", tag}, oes, exp_oe(w));
    chk(per_ok, {"R3 mdc period ", tag}, 64'(per_ok), 64'd1);
    rd(2'd1, v);
    chk(v == 32'h4, {"R7 idle status ", tag}, 64'(v), 64'h4);
    rd(2'd0, v);
    chk(v == exp_word(w, rep), {is_read(w) ? "R5" : "R6", " readback ", tag},
        64'(v), 64'(exp_word(w, rep)));
    chk(!mdc && !mdio_oe, {"R10 idle lines ", tag}, {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    logic [15:0] rep;
    int r0;
    void'($urandom(32'd20250611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    rd(2'd1, v);
    chk(v == 32'h4, "R7 reset status", 64'(v), 64'h4);
    rd(2'd0, v);
    chk(v == 32'h0, "R10 reset word", 64'(v), 64'h0);
    chk(!mdc && !mdio_oe, "R10 reset lines", {62'd0, mdc, mdio_oe}, 64'd0);

    run_frame(mk_word(2'b01, 5'd3, 5'd0, 16'hA5C3), 16'h0, 1'b0, 32'h0, "write");
    run_frame(mk_word(2'b10, 5'd31, 5'd1, 16'h0), 16'hFFFF, 1'b0, 32'h0, "read ones");
    run_frame(mk_word(2'b10, 5'd0, 5'd31, 16'hFFFF), 16'h0000, 1'b0, 32'h0, "read zeros");
    run_frame(mk_word(2'b11, 5'd7, 5'd9, 16'h1234), 16'hBEEF, 1'b0, 32'h0, "op11");
    // R9: write during a frame must not disturb it
    run_frame(mk_word(2'b10, 5'd5, 5'd2, 16'h0), 16'h8001, 1'b1,
              mk_word(2'b01, 5'd1, 5'd1, 16'h5555), "R9 busy write");

    // R8: disabled port
    rd(2'd0, w);
    mgmt_en = 1'b0;
    r0 = nrise;
    wr(mk_word(2'b01, 5'd2, 5'd2, 16'h7777));
    repeat (100) @(posedge clk);
    chk(nrise == r0, "R8 no mdc while disabled", 64'(nrise), 64'(r0));
    rd(2'd1, v);
    chk(v == 32'h4, "R8 stays idle", 64'(v), 64'h4);
    rd(2'd0, v);
    chk(v == w, "R8 word unchanged", 64'(v), 64'(w));
    mgmt_en = 1'b1;

    for (int i = 0; i < 6; i++) begin
      w = mk_word(($urandom % 2) ? 2'b10 : 2'b01, 5'($urandom), 5'($urandom), 16'($urandom));
      rep = 16'($urandom);
      run_frame(w, rep, 1'b0, 32'h0, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule